// File: doc/BRIEF.md
# AC97 Serial Link Frame Engine

This block sits between the system-clock side of a chip and an AC97 audio codec. It drives the serial link toward the codec: the frame marker `sync`, the outgoing serial bit stream and the codec's active-low reset. It also deserializes the incoming bit stream. Every outgoing frame carries one left and one right 18-bit playback sample and, optionally, one pending register command. Every incoming frame yields one left and one right 18-bit record sample and a check of its tag bits.

All serial timing runs from the bit clock that the codec supplies. Outgoing bits are launched on its rising edge and incoming bits are sampled on its falling edge. The parallel side runs on the system clock. Once per frame the block raises `frame_ready` for exactly one system cycle.

- While `frame_ready` is high, the record outputs and `tag_error` already show the newest received frame.
- At the end of that same cycle, the playback and command inputs are taken in.
- A register sequencer and a user datapath use this pulse as their exchange point.

A frame is 256 bit clocks long: a 16-bit tag phase followed by twelve 20-bit slots.

Top module: `ac_link_engine`

## Requirements
- R1: Each frame lasts 256 bit clocks, and `sync` is high for exactly the first 16 bit clocks of every frame.
- R2: The outgoing tag is sent first-bit-first as tag[15:0]. tag[15] (the frame-valid bit) is 1, and tag[12] and tag[11] (slots 3 and 4) are always 1. tag[14] (slot 1) is 1 only when a command is pending. tag[13] (slot 2) is 1 only when a write command is pending. All other tag bits are 0.
- R3: Slot 1 is {read flag, 7-bit register index, 12 zeros}. Slot 2 is {16-bit write data, 4 zeros} for a write and all zero otherwise. Both slots are all zero when no command is pending.
- R4: Playback samples are placed MSB-aligned in slot 3 (left) and slot 4 (right), with the two slot LSBs at 0. Slots 5 to 12 are sent as 0.
- R5: Bits [19:2] of incoming slot 3 and slot 4 appear on `rec_left` and `rec_right`. They change only in the cycle in which `frame_ready` is high, and the received slot LSBs and slots 1, 2 and 5 to 12 are ignored.
- R6: `tag_error` is 0 only when incoming tag bits 15 (codec ready), 12 and 11 (slot 3 and 4 valid) are all 1. Other tag bits have no effect. It is updated together with `frame_ready`.
- R7: `frame_ready` is exactly one system clock wide and occurs once per frame.
- R8: The playback and command inputs are sampled only at the system clock edge that ends the `frame_ready` cycle, and they are sent in the next frame. Changes at any other time have no effect.
- R9: `codec_rst_n` is 0 while `sys_rst_n` is 0 and for `RST_HOLD` system clock edges after release, then 1. While the codec is held in reset, `sync`, `sdata_out` and `frame_ready` stay 0.
- R10: Outgoing bits change on the rising edge of `bit_clk`. Incoming bits are sampled on its falling edge, so a bit driven shortly after a rising edge is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low system reset |
| bit_clk | input | 1 | Serial bit clock supplied by the codec |
| sdata_in | input | 1 | Serial data from the codec |
| play_left | input | 18 | Left playback sample |
| play_right | input | 18 | Right playback sample |
| cmd_valid | input | 1 | A register command is pending |
| cmd_read | input | 1 | 1 = read command, 0 = write command |
| cmd_index | input | 7 | Codec register index |
| cmd_data | input | 16 | Write data for the command |
| sync | output | 1 | Frame marker toward the codec |
| sdata_out | output | 1 | Serial data toward the codec |
| codec_rst_n | output | 1 | Active-low codec reset |
| frame_ready | output | 1 | One-cycle per-frame exchange pulse |
| rec_left | output | 18 | Left record sample |
| rec_right | output | 18 | Right record sample |
| tag_error | output | 1 | Incoming tag check failed |

## Verification
Record samples and `tag_error` are due in the very cycle `frame_ready` is high. The bench therefore waits for the pulse by sampling on falling system-clock edges and compares at that sample. Playback and command values take effect one frame later, so the bench drives a vector in the pulse cycle and overwrites the inputs with junk one cycle afterwards. It then compares the whole 256-bit frame captured by its codec model once that frame is complete. `codec_rst_n` is due exactly `RST_HOLD` edges after reset release, and it is sampled one edge before and at that point. The frame period is measured in system cycles between pulses, with one cycle of slack allowed for the synchronizer.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;
  localparam int FRAME_BITS = 256;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int SAMPLE_W   = 18;
  localparam int IDX_W      = 7;
  localparam int CDATA_W    = 16;
  localparam int PAD_W      = SLOT_BITS - SAMPLE_W;
  localparam int TAIL_W     = FRAME_BITS - TAG_BITS - 4 * SLOT_BITS;

  // bit index within a frame of the last bit of each slot (0 = first bit sent)
  localparam int TAG_END    = TAG_BITS - 1;
  localparam int LEFT_END   = TAG_BITS + 3 * SLOT_BITS - 1;
  localparam int RIGHT_END  = TAG_BITS + 4 * SLOT_BITS - 1;

  typedef struct packed {
    logic [SAMPLE_W-1:0] left;
    logic [SAMPLE_W-1:0] right;
    logic                cmd_v;
    logic                cmd_rd;
    logic [IDX_W-1:0]    cmd_idx;
    logic [CDATA_W-1:0]  cmd_data;
  } play_word_t;

  typedef struct packed {
    logic [SAMPLE_W-1:0] left;
    logic [SAMPLE_W-1:0] right;
    logic                bad_tag;
  } rec_word_t;

  function automatic logic [SLOT_BITS-1:0] pack_sample(input logic [SAMPLE_W-1:0] s);
    return {s, {PAD_W{1'b0}}};
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input play_word_t w);
    logic [TAG_BITS-1:0]  tag;
    logic [SLOT_BITS-1:0] addr_slot;
    logic [SLOT_BITS-1:0] data_slot;
    logic                 is_wr;
    is_wr     = w.cmd_v & ~w.cmd_rd;
    tag       = '0;
    tag[15]   = 1'b1;
    tag[14]   = w.cmd_v;
    tag[13]   = is_wr;
    tag[12]   = 1'b1;
    tag[11]   = 1'b1;
    addr_slot = w.cmd_v ? {w.cmd_rd, w.cmd_idx, {(SLOT_BITS-1-IDX_W){1'b0}}} : '0;
    data_slot = is_wr ? {w.cmd_data, {(SLOT_BITS-CDATA_W){1'b0}}} : '0;
    return {tag, addr_slot, data_slot, pack_sample(w.left), pack_sample(w.right),
            {TAIL_W{1'b0}}};
  endfunction

  function automatic logic tag_is_good(input logic [TAG_BITS-1:0] t);
    return t[15] & t[12] & t[11];
  endfunction
endpackage

// File: rtl/ac_link_sync2.sv
module ac_link_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ac_link_reset_ctrl.sv
module ac_link_reset_ctrl #(
  parameter int RST_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic codec_rst_n
);
  localparam int CW = $clog2(RST_HOLD + 1);

  logic [CW-1:0] hold_cnt;
  logic          released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      released <= 1'b0;
    end else if (!released) begin
      if (hold_cnt == CW'(RST_HOLD - 1)) released <= 1'b1;
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign codec_rst_n = released;

  AST_CODEC_RST_LOW_IN_RESET: assert property (@(posedge clk) !rst_n |=> !codec_rst_n);  // R9
endmodule

// File: rtl/ac_link_tx_framer.sv
module ac_link_tx_framer
  import ac_link_pkg::*;
#(
  parameter int READY_BIT = 128,
  parameter int READY_LEN = 16
) (
  input  logic             bit_clk,
  input  logic             run,
  input  play_word_t       word,
  output logic [CNT_W-1:0] bit_pos,
  output logic             sync,
  output logic             sdata,
  output logic             ready_lvl
);
  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TAG_LIM   = CNT_W'(TAG_BITS);
  localparam logic [CNT_W-1:0] RDY_LO    = CNT_W'(READY_BIT);
  localparam logic [CNT_W-1:0] RDY_HI    = CNT_W'(READY_BIT + READY_LEN);
  localparam logic [CNT_W-1:0] L_PAD     = CNT_W'(LEFT_END - 1);
  localparam logic [CNT_W-1:0] R_PAD     = CNT_W'(RIGHT_END - 1);

  logic [CNT_W-1:0]      pos_q;
  logic [CNT_W-1:0]      pos_nxt;
  logic [FRAME_BITS-1:0] shift_q;
  logic [FRAME_BITS-1:0] fresh;
  logic                  sync_q;
  logic                  sdata_q;
  logic                  ready_q;

  assign pos_nxt = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  assign fresh   = build_frame(word);

  always_ff @(posedge bit_clk) begin
    if (!run) begin
      pos_q   <= LAST_POS;
      shift_q <= '0;
      sync_q  <= 1'b0;
      sdata_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      pos_q   <= pos_nxt;
      sync_q  <= (pos_nxt < TAG_LIM);
      ready_q <= (pos_nxt >= RDY_LO) && (pos_nxt < RDY_HI);
      if (pos_nxt == '0) begin
        sdata_q <= fresh[FRAME_BITS-1];
        shift_q <= {fresh[FRAME_BITS-2:0], 1'b0};
      end else begin
        sdata_q <= shift_q[FRAME_BITS-1];
        shift_q <= {shift_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  assign bit_pos   = pos_q;
  assign sync      = sync_q;
  assign sdata     = sdata_q;
  assign ready_lvl = ready_q;

  AST_SYNC_START:      assert property (@(posedge bit_clk) disable iff (!run) $rose(sync_q) |-> (pos_q == '0));  // R1
  AST_SYNC_END:        assert property (@(posedge bit_clk) disable iff (!run) (sync_q && pos_q == TAG_LIM - 1'b1) |=> !sync_q);  // R1
  AST_FRAME_VALID_BIT: assert property (@(posedge bit_clk) disable iff (!run) (pos_q == '0) |-> sdata_q);  // R2
  AST_PAD_BITS_LOW:    assert property (@(posedge bit_clk) disable iff (!run) (pos_q == L_PAD || pos_q == L_PAD + 1'b1 || pos_q == R_PAD || pos_q == R_PAD + 1'b1) |-> !sdata_q);  // R4
endmodule

// File: rtl/ac_link_rx_capture.sv
module ac_link_rx_capture
  import ac_link_pkg::*;
(
  input  logic             bit_clk,
  input  logic             run,
  input  logic             sdata_in,
  input  logic [CNT_W-1:0] bit_pos,
  output logic [TAG_BITS-1:0] tag,
  output logic [SAMPLE_W-1:0] left,
  output logic [SAMPLE_W-1:0] right
);
  localparam logic [CNT_W-1:0] P_TAG   = CNT_W'(TAG_END);
  localparam logic [CNT_W-1:0] P_LEFT  = CNT_W'(LEFT_END);
  localparam logic [CNT_W-1:0] P_RIGHT = CNT_W'(RIGHT_END);

  logic [SLOT_BITS-2:0] sh_q;
  logic [SLOT_BITS-1:0] sh_nxt;
  logic [TAG_BITS-1:0]  tag_q;
  logic [SAMPLE_W-1:0]  left_q;
  logic [SAMPLE_W-1:0]  right_q;

  assign sh_nxt = {sh_q, sdata_in};

  always_ff @(negedge bit_clk) begin
    if (!run) begin
      sh_q    <= '0;
      tag_q   <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      sh_q <= sh_nxt[SLOT_BITS-2:0];
      if (bit_pos == P_TAG)   tag_q   <= sh_nxt[TAG_BITS-1:0];
      if (bit_pos == P_LEFT)  left_q  <= sh_nxt[SLOT_BITS-1:PAD_W];
      if (bit_pos == P_RIGHT) right_q <= sh_nxt[SLOT_BITS-1:PAD_W];
    end
  end

  assign tag   = tag_q;
  assign left  = left_q;
  assign right = right_q;

  AST_TAG_HELD_OUTSIDE_PHASE: assert property (@(negedge bit_clk) disable iff (!run) (bit_pos != P_TAG) |=> $stable(tag_q));  // R6
endmodule

// File: rtl/ac_link_sys_port.sv
module ac_link_sys_port
  import ac_link_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ready_lvl,
  input  play_word_t          play_in,
  input  logic [TAG_BITS-1:0] rx_tag,
  input  logic [SAMPLE_W-1:0] rx_left,
  input  logic [SAMPLE_W-1:0] rx_right,
  output play_word_t          play_hold,
  output rec_word_t           rec_out,
  output logic                frame_ready
);
  logic       rdy_s;
  logic       rdy_d;
  logic       rdy_edge;
  logic       pulse_q;
  play_word_t hold_q;
  rec_word_t  rec_q;

  ac_link_sync2 #(.STAGES(2)) u_rdy_sync (
    .clk (clk),
    .d   (ready_lvl),
    .q   (rdy_s)
  );

  assign rdy_edge = rdy_s & ~rdy_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_d   <= 1'b0;
      pulse_q <= 1'b0;
      hold_q  <= '0;
      rec_q   <= '0;
    end else begin
      rdy_d   <= rdy_s;
      pulse_q <= rdy_edge;
      if (rdy_edge) begin
        rec_q.left    <= rx_left;
        rec_q.right   <= rx_right;
        rec_q.bad_tag <= ~tag_is_good(rx_tag);
      end
      if (pulse_q) hold_q <= play_in;
    end
  end

  assign play_hold   = hold_q;
  assign rec_out     = rec_q;
  assign frame_ready = pulse_q;

  AST_READY_ONE_CYCLE:    assert property (@(posedge clk) disable iff (!rst_n) pulse_q |=> !pulse_q);  // R7
  AST_HOLD_ONLY_ON_READY: assert property (@(posedge clk) disable iff (!rst_n) !pulse_q |=> $stable(hold_q));  // R8
  AST_REC_ONLY_ON_READY:  assert property (@(posedge clk) disable iff (!rst_n) !$stable(rec_q) |-> pulse_q);  // R5
endmodule

// File: rtl/ac_link_engine.sv
module ac_link_engine
  import ac_link_pkg::*;
#(
  parameter int RST_HOLD  = 16,
  parameter int READY_BIT = 128,
  parameter int READY_LEN = 16
) (
  input  logic                sys_clk,
  input  logic                sys_rst_n,
  input  logic                bit_clk,
  input  logic                sdata_in,
  input  logic [SAMPLE_W-1:0] play_left,
  input  logic [SAMPLE_W-1:0] play_right,
  input  logic                cmd_valid,
  input  logic                cmd_read,
  input  logic [IDX_W-1:0]    cmd_index,
  input  logic [CDATA_W-1:0]  cmd_data,
  output logic                sync,
  output logic                sdata_out,
  output logic                codec_rst_n,
  output logic                frame_ready,
  output logic [SAMPLE_W-1:0] rec_left,
  output logic [SAMPLE_W-1:0] rec_right,
  output logic                tag_error
);
  logic                codec_live;
  logic                bit_run;
  logic [CNT_W-1:0]    bit_pos;
  logic                ready_lvl;
  logic [TAG_BITS-1:0] rx_tag;
  logic [SAMPLE_W-1:0] rx_left;
  logic [SAMPLE_W-1:0] rx_right;
  play_word_t          play_in;
  play_word_t          play_hold;
  rec_word_t           rec_out;

  assign play_in = '{left: play_left, right: play_right, cmd_v: cmd_valid,
                     cmd_rd: cmd_read, cmd_idx: cmd_index, cmd_data: cmd_data};

  ac_link_reset_ctrl #(.RST_HOLD(RST_HOLD)) u_rst (
    .clk         (sys_clk),
    .rst_n       (sys_rst_n),
    .codec_rst_n (codec_live)
  );

  ac_link_sync2 #(.STAGES(2)) u_run_sync (
    .clk (bit_clk),
    .d   (codec_live),
    .q   (bit_run)
  );

  ac_link_tx_framer #(.READY_BIT(READY_BIT), .READY_LEN(READY_LEN)) u_tx (
    .bit_clk   (bit_clk),
    .run       (bit_run),
    .word      (play_hold),
    .bit_pos   (bit_pos),
    .sync      (sync),
    .sdata     (sdata_out),
    .ready_lvl (ready_lvl)
  );

  ac_link_rx_capture u_rx (
    .bit_clk  (bit_clk),
    .run      (bit_run),
    .sdata_in (sdata_in),
    .bit_pos  (bit_pos),
    .tag      (rx_tag),
    .left     (rx_left),
    .right    (rx_right)
  );

  ac_link_sys_port u_sys (
    .clk         (sys_clk),
    .rst_n       (sys_rst_n),
    .ready_lvl   (ready_lvl),
    .play_in     (play_in),
    .rx_tag      (rx_tag),
    .rx_left     (rx_left),
    .rx_right    (rx_right),
    .play_hold   (play_hold),
    .rec_out     (rec_out),
    .frame_ready (frame_ready)
  );

  assign codec_rst_n = codec_live;
  assign rec_left    = rec_out.left;
  assign rec_right   = rec_out.right;
  assign tag_error   = rec_out.bad_tag;

  AST_READY_NEEDS_CODEC: assert property (@(posedge sys_clk) disable iff (!sys_rst_n) frame_ready |-> codec_rst_n);  // R9
endmodule

// File: tb/tb_ac_link_engine.sv
`timescale 1ns/1ps
module tb_ac_link_engine;
  localparam int RST_HOLD = 16;
  localparam int NV = 6;
  localparam int SYS_PER_FRAME = 4096;

  typedef struct packed {
    logic [17:0] l;
    logic [17:0] r;
    logic        cv;
    logic        crd;
    logic [6:0]  ci;
    logic [15:0] cd;
    logic [17:0] rl;
    logic [17:0] rr;
    logic [15:0] rtag;
    logic        err;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{18'h3FFFF, 18'h00001, 1'b0, 1'b0, 7'h00, 16'h0000, 18'h2AAAA, 18'h15555, 16'h9800, 1'b0},
    '{18'h12345, 18'h2ABCD, 1'b1, 1'b0, 7'h02, 16'h8000, 18'h00000, 18'h3FFFF, 16'hF800, 1'b0},
    '{18'h0F0F0, 18'h30303, 1'b1, 1'b1, 7'h7C, 16'hFFFF, 18'h1E1E1, 18'h00F00, 16'h1800, 1'b1},
    '{18'h00000, 18'h3FFFF, 1'b1, 1'b0, 7'h18, 16'h0808, 18'h3C3C3, 18'h04040, 16'h9000, 1'b1},
    '{18'h20001, 18'h10002, 1'b0, 1'b1, 7'h55, 16'h1234, 18'h11111, 18'h22222, 16'h8800, 1'b1},
    '{18'h00000, 18'h00000, 1'b0, 1'b0, 7'h00, 16'h0000, 18'h00000, 18'h00000, 16'h9800, 1'b0}
  };

  logic        sys_clk = 1'b0;
  logic        bit_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        sdata_in = 1'b0;
  logic [17:0] play_left = '0;
  logic [17:0] play_right = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_read = 1'b0;
  logic [6:0]  cmd_index = '0;
  logic [15:0] cmd_data = '0;
  logic        sync;
  logic        sdata_out;
  logic        codec_rst_n;
  logic        frame_ready;
  logic [17:0] rec_left;
  logic [17:0] rec_right;
  logic        tag_error;

  int total = 0;
  int bad = 0;

  // codec model state
  logic [255:0] rx_next = '0;
  logic [255:0] rx_cur = '0;
  logic [255:0] tx_cap = '0;
  logic [255:0] last_tx = '0;
  int frames_done = 0;
  int sync_hi = 0;
  int last_sync_hi = 0;

  ac_link_engine #(.RST_HOLD(RST_HOLD)) dut (
    .sys_clk     (sys_clk),
    .sys_rst_n   (sys_rst_n),
    .bit_clk     (bit_clk),
    .sdata_in    (sdata_in),
    .play_left   (play_left),
    .play_right  (play_right),
    .cmd_valid   (cmd_valid),
    .cmd_read    (cmd_read),
    .cmd_index   (cmd_index),
    .cmd_data    (cmd_data),
    .sync        (sync),
    .sdata_out   (sdata_out),
    .codec_rst_n (codec_rst_n),
    .frame_ready (frame_ready),
    .rec_left    (rec_left),
    .rec_right   (rec_right),
    .tag_error   (tag_error)
  );

  initial forever #2.5 sys_clk = ~sys_clk;
  initial forever #40 bit_clk = ~bit_clk;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected outgoing frame, bit 255 sent first
  function automatic logic [255:0] exp_tx(input vec_t v);
    logic [255:0] f;
    f = '0;
    f[255] = 1'b1;
    f[254] = v.cv;
    f[253] = v.cv & ~v.crd;
    f[252] = 1'b1;
    f[251] = 1'b1;
    if (v.cv) begin
      f[239] = v.crd;
      f[238:232] = v.ci;
      if (!v.crd) f[219:204] = v.cd;
    end
    f[199:182] = v.l;
    f[179:162] = v.r;
    return f;
  endfunction

  // incoming frame with junk in every field the block must ignore
  function automatic logic [255:0] rx_frame(input vec_t v);
    return {v.rtag, 20'hFFFFF, 20'hABCDE, v.rl, 2'b11, v.rr, 2'b01, {8{20'h5A5A5}}};
  endfunction

  task automatic drive(input vec_t v);
    play_left = v.l; play_right = v.r; cmd_valid = v.cv;
    cmd_read = v.crd; cmd_index = v.ci; cmd_data = v.cd;
  endtask

  task automatic drive_junk();
    play_left = 18'h2DEAD; play_right = 18'h1BEEF; cmd_valid = 1'b1;
    cmd_read = 1'b0; cmd_index = 7'h6B; cmd_data = 16'hC0DE;
  endtask

  task automatic wait_ready();
    @(negedge sys_clk);
    while (frame_ready !== 1'b1) @(negedge sys_clk);
  endtask

  task automatic wait_frame();
    int start;
    start = frames_done;
    while (frames_done == start) @(negedge sys_clk);
  endtask

  // codec model: reacts to sync, drives sdata_in after each rising edge
  initial begin
    int idx;
    logic prev;
    logic started;
    idx = 0; prev = 1'b0; started = 1'b0;
    forever begin
      @(posedge bit_clk);
      #2;
      if (sync && !prev) begin
        idx = 0; started = 1'b1; rx_cur = rx_next; sync_hi = 0;
      end else begin
        idx++;
      end
      prev = sync;
      if (sync) sync_hi++;
      if (started && idx < 256) begin
        tx_cap[255-idx] = sdata_out;
        sdata_in = rx_cur[255-idx];
        if (idx == 255) begin
          last_tx = tx_cap;
          last_sync_hi = sync_hi;
          frames_done++;
        end
      end else begin
        sdata_in = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    total++; bad++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (100) @(negedge sys_clk);
    chk("R9 codec_rst_n in reset", 256'(codec_rst_n), 256'(0));
    chk("R9 sync in reset", 256'(sync), 256'(0));
    chk("R9 sdata_out in reset", 256'(sdata_out), 256'(0));
    chk("R9 frame_ready in reset", 256'(frame_ready), 256'(0));

    sys_rst_n = 1'b1;
    repeat (RST_HOLD - 1) @(negedge sys_clk);
    chk("R9 codec_rst_n one edge before hold ends", 256'(codec_rst_n), 256'(0));
    @(negedge sys_clk);
    chk("R9 codec_rst_n after hold", 256'(codec_rst_n), 256'(1));

    wait_ready();
    drive(VECS[0]);
    rx_next = rx_frame(VECS[0]);
    @(negedge sys_clk);
    drive_junk();  // R8: late changes must not reach the frame

    for (int i = 0; i < NV; i++) begin
      wait_ready();
      chk("R5 R10 rec_left", 256'(rec_left), 256'(VECS[i].rl));
      chk("R5 R10 rec_right", 256'(rec_right), 256'(VECS[i].rr));
      chk("R6 tag_error", 256'(tag_error), 256'(VECS[i].err));
      if (i + 1 < NV) begin
        drive(VECS[i+1]);
        rx_next = rx_frame(VECS[i+1]);
      end
      @(negedge sys_clk);
      drive_junk();
      wait_frame();
      chk("R2 R3 R4 R8 outgoing frame", last_tx, exp_tx(VECS[i]));
      chk("R1 sync width", 256'(last_sync_hi), 256'(16));
    end

    wait_ready();
    n = 0;
    do begin
      @(negedge sys_clk);
      n++;
      if (n == 1) chk("R7 pulse width", 256'(frame_ready), 256'(0));
    end while (frame_ready !== 1'b1);
    chk("R7 R1 frame period in sys cycles", 256'((n >= SYS_PER_FRAME - 1) && (n <= SYS_PER_FRAME + 1)), 256'(1));

    sys_rst_n = 1'b0;
    @(negedge sys_clk);
    chk("R9 codec_rst_n on reset", 256'(codec_rst_n), 256'(0));
    repeat (10) @(posedge bit_clk);
    @(negedge sys_clk);
    chk("R9 sync stops", 256'(sync), 256'(0));
    chk("R9 sdata_out stops", 256'(sdata_out), 256'(0));
    chk("R9 frame_ready stops", 256'(frame_ready), 256'(0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule